// File: doc/BRIEF.md
# Address Register and Relative Index Generator

This block holds the four signed address registers (components x, y, z and w) used for relative addressing in a vertex processing pipeline. Three kinds of update change the registers. The first is a load of integer lane values that upstream logic has already converted from floating point, taking either the floored or the rounded copy. The second is a pairwise add of the components. The third is a restore of a saved register set. Every update is applied lane by lane under a write mask, and no ordinary destination register is written.

On the read side, the block selects one address component with a 2-bit selector. It adds that component to the base index of the instruction, giving three effective indices: one for constant fetches, one for attribute fetches and one for export writes. Each index has its own relative-enable bit. A zero-override input forces the selected component to be read as zero. The constant index is also range-checked, and a 2-bit remap code tells the constant memory controller whether to use the index as it is, to return all zeros, or to read constant 1.

Top module: `addr_index_gen`

## Requirements
- R1: After reset all four address components read zero, and an update class of 0 (idle) leaves them unchanged.
- R2: Update class 1 loads the floored lanes and class 2 loads the rounded lanes. Lane i takes bits [11i+10:11i], with i = 0 for x, 1 for y, 2 for z and 3 for w. Lane i is written only when mask bit 3-i is set, so bit 3 is x and bit 0 is w. A zero mask changes nothing.
- R3: Classes 1, 2 and 3 take effect only when the destination register number is even. With an odd number all components are held.
- R4: Class 3 (pairwise add) sets the components to (x+z, y+w, x+z, y+w) under the write mask. The sums are taken from the values held before the update.
- R5: Class 4 (restore) loads the restore lanes under the write mask, whether the destination number is even or odd.
- R6: Each effective index is the selected component (selector 0 = x, 1 = y, 2 = z, 3 = w), sign-extended to 12 bits, plus the zero-extended base index. The indices follow the registers combinationally.
- R7: The remap code is 1 (return zeros) when the constant index is above 1023, 2 (read constant 1) when it is below 0, and 0 (use the index) when it lies in 0..1023.
- R8: When the relative-enable bit of an index is low, that index equals its base index.
- R9: When zero-override is high, every index equals its base index, and the registers are not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_class | input | 3 | Update class: 0 idle, 1 floor load, 2 round load, 3 pairwise add, 4 restore |
| wr_mask | input | 4 | Lane write mask, bit 3 = x, bit 0 = w |
| dst_reg | input | 6 | Destination register number; its parity gates classes 1 to 3 |
| floor_lanes | input | 44 | Floored integer lanes, 11 bits each, x in the lowest bits |
| round_lanes | input | 44 | Rounded integer lanes, same packing |
| restore_lanes | input | 44 | Saved register set, same packing |
| addr_sel | input | 2 | Address component selector |
| zero_ovr | input | 1 | Read the selected component as zero |
| cst_rel_en | input | 1 | Relative addressing enable, constant index |
| atr_rel_en | input | 1 | Relative addressing enable, attribute index |
| exp_rel_en | input | 1 | Relative addressing enable, export index |
| cst_base | input | 10 | Constant base index |
| atr_base | input | 4 | Attribute base index |
| exp_base | input | 5 | Export base index |
| a_regs | output | 44 | Current address components, same packing |
| cst_index | output | 12 | Effective constant index, signed |
| cst_remap | output | 2 | Constant remap code |
| atr_index | output | 12 | Effective attribute index, signed |
| exp_index | output | 12 | Effective export index, signed |

## Verification
An update presented before a rising edge shows on `a_regs` after that edge, one register stage later. The indices and the remap code are purely combinational from the registers, the selector and the bases, so they settle within the same cycle. The bench drives each update on a falling edge and lets exactly one rising edge pass. It returns the class to idle just after that edge and samples every output at the next falling edge. Each table entry therefore checks one update together with the index arithmetic on the resulting state. The directed tests change only combinational inputs and sample half a cycle later.

// File: rtl/addr_pkg.sv
// Package: shared types for the address register and index generator.
// Assumes lane values arrive already converted to integers upstream.
package addr_pkg;
    typedef enum logic [2:0] {
        AOP_IDLE    = 3'd0,
        AOP_FLOOR   = 3'd1,
        AOP_ROUND   = 3'd2,
        AOP_PAIR    = 3'd3,
        AOP_RESTORE = 3'd4
    } aop_e;

    typedef enum logic [1:0] {
        RM_DIRECT = 2'd0,
        RM_ZERO   = 2'd1,
        RM_INDEX1 = 2'd2
    } remap_e;
endpackage

// File: rtl/addr_reg_file.sv
// Module: holds the address components and applies floor/round loads,
// the pairwise add and the restore, lane by lane under the write mask.
// Assumes the caller supplies the parity of the destination register.
module addr_reg_file
    import addr_pkg::*;
#(
    parameter int AW    = 11,
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            op_class,
    input  logic [LANES-1:0]      wr_mask,
    input  logic                  dst_even,
    input  logic [LANES*AW-1:0]   floor_lanes,
    input  logic [LANES*AW-1:0]   round_lanes,
    input  logic [LANES*AW-1:0]   restore_lanes,
    output logic [LANES*AW-1:0]   a_regs
);
    localparam int HALF = LANES / 2;

    aop_e op;
    logic gated_ok;

    // Decode the update class and the parity gate.
    always_comb begin
        op       = aop_e'(op_class);
        gated_ok = dst_even;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW-1:0] nxt;
        logic          wr;
        logic [AW-1:0] pair_sum;

        // Pairwise sum: lanes i and i+HALF of the lower/upper halves.
        assign pair_sum = a_regs[(i % HALF)*AW +: AW]
                        + a_regs[((i % HALF) + HALF)*AW +: AW];

        // Choose the next value and the write enable of this lane.
        always_comb begin
            nxt = a_regs[i*AW +: AW];
            wr  = 1'b0;
            unique case (op)
                AOP_FLOOR:   begin nxt = floor_lanes[i*AW +: AW];   wr = gated_ok; end
                AOP_ROUND:   begin nxt = round_lanes[i*AW +: AW];   wr = gated_ok; end
                AOP_PAIR:    begin nxt = pair_sum;                  wr = gated_ok; end
                AOP_RESTORE: begin nxt = restore_lanes[i*AW +: AW]; wr = 1'b1;     end
                default:     begin nxt = a_regs[i*AW +: AW];        wr = 1'b0;     end
            endcase
            wr = wr & wr_mask[LANES-1-i];
        end

        // Store the lane, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                a_regs[i*AW +: AW] <= '0;
            else if (wr)
                a_regs[i*AW +: AW] <= nxt;
        end
    end
endmodule

// File: rtl/addr_index_add.sv
// Module: forms one effective index from a signed address component and
// an unsigned base index. Assumes IW exceeds both AW and BW.
module addr_index_add #(
    parameter int AW = 11,
    parameter int BW = 10,
    parameter int IW = 12
) (
    input  logic [AW-1:0]        a_val,
    input  logic                 rel_en,
    input  logic [BW-1:0]        base,
    output logic signed [IW-1:0] idx
);
    logic signed [IW-1:0] a_ext;
    logic signed [IW-1:0] b_ext;

    // Sign-extend the component, zero-extend the base, then add.
    always_comb begin
        a_ext = {{(IW-AW){a_val[AW-1]}}, a_val};
        b_ext = {{(IW-BW){1'b0}}, base};
        idx   = rel_en ? a_ext + b_ext : b_ext;
    end
endmodule

// File: rtl/cst_range_check.sv
// Module: classifies an effective constant index against the size of the
// constant memory, 0 .. 2**CBW-1.
module cst_range_check
    import addr_pkg::*;
#(
    parameter int IW  = 12,
    parameter int CBW = 10
) (
    input  logic signed [IW-1:0] idx,
    output logic [1:0]           remap
);
    localparam logic signed [IW-1:0] CMAX = IW'((1 << CBW) - 1);

    // Pick the remap code: high side reads zero, low side reads entry 1.
    always_comb begin
        if (idx > CMAX)
            remap = RM_ZERO;
        else if (idx < 0)
            remap = RM_INDEX1;
        else
            remap = RM_DIRECT;
    end
endmodule

// File: rtl/addr_index_gen.sv
// Module: top level. It holds the address components and produces the
// constant, attribute and export indices plus the constant remap code.
// Assumes one update class per cycle and integer lanes from upstream.
module addr_index_gen #(
    parameter int AW    = 11,
    parameter int IW    = 12,
    parameter int CBW   = 10,
    parameter int ABW   = 4,
    parameter int EBW   = 5,
    parameter int DW    = 6,
    parameter int LANES = 4,
    localparam int SW   = $clog2(LANES),
    localparam int LW   = LANES * AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           op_class,
    input  logic [LANES-1:0]     wr_mask,
    input  logic [DW-1:0]        dst_reg,
    input  logic [LW-1:0]        floor_lanes,
    input  logic [LW-1:0]        round_lanes,
    input  logic [LW-1:0]        restore_lanes,
    input  logic [SW-1:0]        addr_sel,
    input  logic                 zero_ovr,
    input  logic                 cst_rel_en,
    input  logic                 atr_rel_en,
    input  logic                 exp_rel_en,
    input  logic [CBW-1:0]       cst_base,
    input  logic [ABW-1:0]       atr_base,
    input  logic [EBW-1:0]       exp_base,
    output logic [LW-1:0]        a_regs,
    output logic signed [IW-1:0] cst_index,
    output logic [1:0]           cst_remap,
    output logic signed [IW-1:0] atr_index,
    output logic signed [IW-1:0] exp_index
);
    logic [AW-1:0] sel_val;

    addr_reg_file #(.AW(AW), .LANES(LANES)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_class      (op_class),
        .wr_mask       (wr_mask),
        .dst_even      (~dst_reg[0]),
        .floor_lanes   (floor_lanes),
        .round_lanes   (round_lanes),
        .restore_lanes (restore_lanes),
        .a_regs        (a_regs)
    );

    // Select the addressed component, or zero when overridden.
    always_comb begin
        sel_val = zero_ovr ? '0 : a_regs[addr_sel*AW +: AW];
    end

    addr_index_add #(.AW(AW), .BW(CBW), .IW(IW)) u_cst_add (
        .a_val (sel_val), .rel_en (cst_rel_en), .base (cst_base), .idx (cst_index)
    );

    addr_index_add #(.AW(AW), .BW(ABW), .IW(IW)) u_atr_add (
        .a_val (sel_val), .rel_en (atr_rel_en), .base (atr_base), .idx (atr_index)
    );

    addr_index_add #(.AW(AW), .BW(EBW), .IW(IW)) u_exp_add (
        .a_val (sel_val), .rel_en (exp_rel_en), .base (exp_base), .idx (exp_index)
    );

    cst_range_check #(.IW(IW), .CBW(CBW)) u_range (
        .idx   (cst_index),
        .remap (cst_remap)
    );
endmodule

// File: rtl/addr_index_chk.sv
// Module: property checker bound to the top level. It watches the update
// rules and the remap classification through the top-level ports.
module addr_index_chk #(
    parameter int AW    = 11,
    parameter int IW    = 12,
    parameter int CBW   = 10,
    parameter int EBW   = 5,
    parameter int DW    = 6,
    parameter int LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [2:0]             op_class,
    input logic [LANES-1:0]       wr_mask,
    input logic [DW-1:0]          dst_reg,
    input logic [LANES*AW-1:0]    a_regs,
    input logic signed [IW-1:0]   cst_index,
    input logic [1:0]             cst_remap,
    input logic                   exp_rel_en,
    input logic [EBW-1:0]         exp_base,
    input logic signed [IW-1:0]   exp_index
);
    localparam logic signed [IW-1:0] CMAX = IW'((1 << CBW) - 1);

    // R1: idle class holds all components
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 3'd0 |=> $stable(a_regs));

    // R2: an empty mask holds all components
    a_r2_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask == '0 |=> $stable(a_regs));

    // R3: odd destination blocks loads and the pairwise add
    a_r3_odd_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class inside {3'd1, 3'd2, 3'd3}) && dst_reg[0] |=> $stable(a_regs));

    // R4: a full-mask pairwise add leaves x equal to z
    a_r4_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 3'd3 && !dst_reg[0] && wr_mask == '1
        |=> a_regs[0 +: AW] == a_regs[2*AW +: AW]);

    // R7: remap code follows the constant index range
    a_r7_remap_high: assert property (@(posedge clk) disable iff (!rst_n)
        cst_index > CMAX |-> cst_remap == 2'd1);
    a_r7_remap_low: assert property (@(posedge clk) disable iff (!rst_n)
        cst_index < 0 |-> cst_remap == 2'd2);
    a_r7_remap_mid: assert property (@(posedge clk) disable iff (!rst_n)
        cst_index >= 0 && cst_index <= CMAX |-> cst_remap == 2'd0);

    // R8: export index falls back to the base without relative addressing
    a_r8_exp_base: assert property (@(posedge clk) disable iff (!rst_n)
        !exp_rel_en |-> exp_index == IW'(exp_base));
endmodule

bind addr_index_gen addr_index_chk #(
    .AW(AW), .IW(IW), .CBW(CBW), .EBW(EBW), .DW(DW), .LANES(LANES)
) u_chk (.*);

// File: tb/tb_addr_index_gen.sv
module tb_addr_index_gen;
    localparam int CLK_PERIOD = 10;
    localparam logic [43:0] JUNK = 44'h5A5_A5A5_A5A5;

    function automatic logic [43:0] pk(int x, int y, int z, int w);
        return {11'(w), 11'(z), 11'(y), 11'(x)};
    endfunction

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  mask;
        logic [5:0]  dst;
        logic [43:0] lanes;
        logic [1:0]  sel;
        logic [9:0]  cbase;
        logic [43:0] regs;
        logic [11:0] cidx;
        logic [1:0]  remap;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 4'b1111, 6'd0,  pk(5, -3, 100, -1023), 2'd0, 10'd10,   pk(5, -3, 100, -1023),       12'd15,    2'd0},
        '{3'd2, 4'b0101, 6'd2,  pk(7, 8, 9, 10),        2'd1, 10'd1020, pk(5, 8, 100, 10),           12'd1028,  2'd1},
        '{3'd1, 4'b1111, 6'd3,  pk(1, 1, 1, 1),         2'd3, 10'd0,    pk(5, 8, 100, 10),           12'd10,    2'd0},
        '{3'd3, 4'b1111, 6'd4,  pk(0, 0, 0, 0),         2'd2, 10'd5,    pk(105, 18, 105, 18),        12'd110,   2'd0},
        '{3'd1, 4'b1000, 6'd0,  pk(-20, 0, 0, 0),       2'd0, 10'd19,   pk(-20, 18, 105, 18),        12'hFFF,   2'd2},
        '{3'd4, 4'b1111, 6'd1,  pk(-1023, 1023, 0, -1), 2'd1, 10'd1023, pk(-1023, 1023, 0, -1),      12'd2046,  2'd1},
        '{3'd3, 4'b0011, 6'd62, pk(0, 0, 0, 0),         2'd3, 10'd1,    pk(-1023, 1023, -1023, 1022), 12'd1023, 2'd0},
        '{3'd3, 4'b1111, 6'd5,  pk(0, 0, 0, 0),         2'd2, 10'd1023, pk(-1023, 1023, -1023, 1022), 12'd0,    2'd0},
        '{3'd0, 4'b1111, 6'd0,  pk(9, 9, 9, 9),         2'd0, 10'd1022, pk(-1023, 1023, -1023, 1022), 12'hFFF,  2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_class = '0;
    logic [3:0]  wr_mask = '0;
    logic [5:0]  dst_reg = '0;
    logic [43:0] floor_lanes = '0, round_lanes = '0, restore_lanes = '0;
    logic [1:0]  addr_sel = '0;
    logic        zero_ovr = 1'b0;
    logic        cst_rel_en = 1'b1, atr_rel_en = 1'b1, exp_rel_en = 1'b1;
    logic [9:0]  cst_base = '0;
    logic [3:0]  atr_base = 4'd3;
    logic [4:0]  exp_base = 5'd2;
    logic [43:0] a_regs;
    logic signed [11:0] cst_index, atr_index, exp_index;
    logic [1:0]  cst_remap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_index_gen dut (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .wr_mask(wr_mask),
        .dst_reg(dst_reg), .floor_lanes(floor_lanes), .round_lanes(round_lanes),
        .restore_lanes(restore_lanes), .addr_sel(addr_sel), .zero_ovr(zero_ovr),
        .cst_rel_en(cst_rel_en), .atr_rel_en(atr_rel_en), .exp_rel_en(exp_rel_en),
        .cst_base(cst_base), .atr_base(atr_base), .exp_base(exp_base),
        .a_regs(a_regs), .cst_index(cst_index), .cst_remap(cst_remap),
        .atr_index(atr_index), .exp_index(exp_index)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane_of(logic [43:0] r, int s);
        logic [10:0] v;
        v = r[s*11 +: 11];
        return int'($signed(v));
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cst_base = 10'd7;
        #1;
        // R1: reset state
        chk("R1 reset regs", a_regs, 0);
        chk("R1 reset cst index", cst_index, 7);

        // Table walk: one update, then outputs on the resulting state
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_class      = VECS[i].op;
            wr_mask       = VECS[i].mask;
            dst_reg       = VECS[i].dst;
            floor_lanes   = (VECS[i].op == 3'd1) ? VECS[i].lanes : JUNK;
            round_lanes   = (VECS[i].op == 3'd2) ? VECS[i].lanes : JUNK;
            restore_lanes = (VECS[i].op == 3'd4) ? VECS[i].lanes : JUNK;
            addr_sel      = VECS[i].sel;
            cst_base      = VECS[i].cbase;
            @(posedge clk);
            #1 op_class = 3'd0;
            @(negedge clk);
            // R2 R3 R4 R5 R1: register state after the update
            chk($sformatf("R2/R3/R4/R5 regs row %0d", i), a_regs, VECS[i].regs);
            // R6: constant index from selected component
            chk($sformatf("R6 cst index row %0d", i), cst_index, $signed(VECS[i].cidx));
            // R7: remap code
            chk($sformatf("R7 remap row %0d", i), cst_remap, VECS[i].remap);
            chk($sformatf("R6 atr index row %0d", i), atr_index,
                lane_of(VECS[i].regs, VECS[i].sel) + 3);
            chk($sformatf("R6 exp index row %0d", i), exp_index,
                lane_of(VECS[i].regs, VECS[i].sel) + 2);
        end

        // R8: relative enables off (regs now x=-1023, y=1023)
        addr_sel = 2'd1; cst_base = 10'd900; atr_base = 4'd9; exp_base = 5'd31;
        cst_rel_en = 1'b0; atr_rel_en = 1'b0; exp_rel_en = 1'b0;
        #1;
        chk("R8 cst base only", cst_index, 900);
        chk("R8 cst remap direct", cst_remap, 0);
        chk("R8 atr base only", atr_index, 9);
        chk("R8 exp base only", exp_index, 31);
        cst_rel_en = 1'b1; atr_rel_en = 1'b1; exp_rel_en = 1'b1;
        #1;
        chk("R6 cst relative again", cst_index, 1923);
        chk("R7 remap above range", cst_remap, 1);

        // R9: zero-override forces the selected value to zero
        zero_ovr = 1'b1;
        #1;
        chk("R9 cst override", cst_index, 900);
        chk("R9 atr override", atr_index, 9);
        chk("R9 exp override", exp_index, 31);
        chk("R9 remap override", cst_remap, 0);
        @(negedge clk);
        chk("R9 regs untouched", a_regs, pk(-1023, 1023, -1023, 1022));
        zero_ovr = 1'b0;

        // R2: empty mask with a floor load changes nothing
        op_class = 3'd1; wr_mask = 4'b0000; dst_reg = 6'd0; floor_lanes = pk(1, 2, 3, 4);
        @(posedge clk);
        #1 op_class = 3'd0;
        @(negedge clk);
        chk("R2 empty mask hold", a_regs, pk(-1023, 1023, -1023, 1022));

        // R1: synchronous reset clears the registers again
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset clears", a_regs, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule